// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block decides whether an address arriving from the expansion bus falls inside one of three inbound memory windows and, if so, which one and at what local memory offset. Software programs each window through a 32-bit register port. A window register holds a bus-side base that is aligned to 1 MB and a 4-bit code that gives the size as a power of two, from 1 MB up to 2 GB. Because every window maps onto local memory starting at address zero, the translated address is the offset of the incoming address inside its window.

A second port takes one address per cycle, marked with a valid strobe. One cycle later the block returns a registered result: valid, hit, the index of the window, and the translated local address. When two or more windows contain the address, the window with the lowest number wins. A separate I/O size register uses the same size encoding. It can be written and read back but plays no part in the lookup. After reset every window is disabled, so no address hits until software sets up the windows.

Top module: `inbound_window_decoder`

## Requirements
- R1: After reset, each window register and the I/O size register read back 0x000F0000 (base 0, size code 0xF), and no lookup hits.
- R2: Windows 0, 1 and 2 sit at register offsets 0x50, 0x54 and 0x58, and the I/O size register sits at offset 0x00. A write stores data bits 31:20 as the base and bits 19:16 as the size code. A read returns those two fields in the same positions, with bits 15:0 read as zero.
- R3: A read of any other offset returns zero. A write to any other offset changes no register and no lookup result.
- R4: With a legal size code c (0x0 to 0xB, giving a size of 2^(20+c) bytes), an address hits the window when its bits 31 down to 20+c equal the same bits of the stored base. Stored base bits below 20+c are ignored.
- R5: A window whose size code is 0xC to 0xF never hits.
- R6: When several windows hit, the result reports the lowest-numbered of them.
- R7: On a hit, the index output gives the winning window, and the translated address equals the address with every bit at or above 20+c cleared.
- R8: The result valid output equals the lookup valid input one cycle earlier. Hit is never asserted without valid.
- R9: On a miss, and in any cycle without a valid result, the index and translated address outputs are zero.
- R10: The I/O size register has no effect on any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_addr_i | input | 32 | Bus-side address to decode |
| lk_valid_o | output | 1 | Lookup result valid, one cycle after the request |
| lk_hit_o | output | 1 | Address fell inside an enabled window |
| lk_idx_o | output | 2 | Index of the winning window |
| lk_loc_o | output | 32 | Translated local address |

## Verification
The hardest case to reach is an address that lies inside two enabled windows at once, with the lower-numbered window later disabled by an illegal size code so that the higher one has to take over. The stimulus places a 1 MB window inside a 16 MB window, confirms that the lower index wins, then rewrites the lower window with codes 0xC and 0xF and looks up the same address again. A 2 GB window is written with junk in its low base bits, which shows that only the bits above the window size are compared.

// File: rtl/iwd_pkg.sv
package iwd_pkg;
    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 20;
    localparam int BASE_W   = ADDR_W - BASE_LSB;
    localparam int CODE_W   = 4;
    localparam int MAX_CODE = 11;
    localparam logic [CODE_W-1:0] OFF_CODE = '1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } win_cfg_t;
endpackage

// File: rtl/iwd_regs.sv
module iwd_regs
    import iwd_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int REG_AW  = 8,
    parameter logic [REG_AW-1:0] WIN_OFS = 8'h50,
    parameter logic [REG_AW-1:0] IO_OFS  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output win_cfg_t          win_cfg_o [NUM_WIN]
);
    localparam int PAD_W = BASE_LSB - CODE_W;

    typedef struct {
        win_cfg_t win [NUM_WIN];
        win_cfg_t io;
    } regs_t;

    regs_t    regs_d, regs_q;
    win_cfg_t wr_cfg;
    logic     unused_low;

    assign wr_cfg     = '{base: wdata[ADDR_W-1:BASE_LSB], code: wdata[BASE_LSB-1:PAD_W]};
    assign unused_low = ^wdata[PAD_W-1:0];

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        if (addr == IO_OFS) begin
            rdata = {regs_q.io, PAD_W'(0)};
            if (we) regs_d.io = wr_cfg;
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (addr == WIN_OFS + REG_AW'(4 * i)) begin
                rdata = {regs_q.win[i], PAD_W'(0)};
                if (we) regs_d.win[i] = wr_cfg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.io <= '{base: '0, code: OFF_CODE};
            for (int i = 0; i < NUM_WIN; i++)
                regs_q.win[i] <= '{base: '0, code: OFF_CODE};
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
        assign win_cfg_o[g] = regs_q.win[g];
    end
endmodule

// File: rtl/iwd_match.sv
module iwd_match
    import iwd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  win_cfg_t          cfg,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] base_full;
    logic              legal;

    always_comb begin
        legal     = (cfg.code <= CODE_W'(MAX_CODE));
        hi_mask   = {ADDR_W{1'b1}} << (BASE_LSB + int'(cfg.code));
        base_full = {cfg.base, BASE_LSB'(0)};
        hit       = legal && (((addr ^ base_full) & hi_mask) == '0);
        offset    = addr & ~hi_mask;
    end
endmodule

// File: rtl/iwd_select.sv
module iwd_select
    import iwd_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_WIN-1:0] hits,
    input  logic [ADDR_W-1:0]  offsets [NUM_WIN],
    output logic               any_hit,
    output logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  loc
);
    always_comb begin
        any_hit = 1'b0;
        idx     = '0;
        loc     = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                idx     = IDX_W'(i);
                loc     = offsets[i];
            end
        end
    end
endmodule

// File: rtl/inbound_window_decoder.sv
module inbound_window_decoder
    import iwd_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int REG_AW  = 8,
    parameter logic [REG_AW-1:0] WIN_OFS = 8'h50,
    parameter logic [REG_AW-1:0] IO_OFS  = 8'h00,
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              lk_valid_o,
    output logic              lk_hit_o,
    output logic [IDX_W-1:0]  lk_idx_o,
    output logic [ADDR_W-1:0] lk_loc_o
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] loc;
    } lk_t;

    win_cfg_t           win_cfg [NUM_WIN];
    logic [NUM_WIN-1:0] hits;
    logic [ADDR_W-1:0]  offsets [NUM_WIN];
    logic               sel_hit;
    logic [IDX_W-1:0]   sel_idx;
    logic [ADDR_W-1:0]  sel_loc;
    lk_t                lk_d, lk_q;

    iwd_regs #(
        .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .WIN_OFS(WIN_OFS), .IO_OFS(IO_OFS)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .win_cfg_o(win_cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        iwd_match match_i (
            .addr(lk_addr_i), .cfg(win_cfg[g]),
            .hit(hits[g]), .offset(offsets[g])
        );
    end

    iwd_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) sel_i (
        .hits(hits), .offsets(offsets),
        .any_hit(sel_hit), .idx(sel_idx), .loc(sel_loc)
    );

    always_comb begin
        lk_d = '0;
        if (lk_valid_i) begin
            lk_d.valid = 1'b1;
            lk_d.hit   = sel_hit;
            lk_d.idx   = sel_idx;
            lk_d.loc   = sel_loc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign lk_valid_o = lk_q.valid;
    assign lk_hit_o   = lk_q.hit;
    assign lk_idx_o   = lk_q.idx;
    assign lk_loc_o   = lk_q.loc;
endmodule

// File: rtl/iwd_checker.sv
module iwd_checker
    import iwd_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int IDX_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid_i,
    input logic [ADDR_W-1:0] lk_addr_i,
    input logic              lk_valid_o,
    input logic              lk_hit_o,
    input logic [IDX_W-1:0]  lk_idx_o,
    input logic [ADDR_W-1:0] lk_loc_o,
    input win_cfg_t          win_cfg [NUM_WIN]
);
    logic any_legal;
    always_comb begin
        any_legal = 1'b0;
        for (int i = 0; i < NUM_WIN; i++)
            if (win_cfg[i].code <= CODE_W'(MAX_CODE)) any_legal = 1'b1;
    end

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> lk_valid_o);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !lk_valid_o);
    p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> lk_valid_o);
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit_o |-> (lk_idx_o == '0 && lk_loc_o == '0));
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> (int'(lk_idx_o) < NUM_WIN));
    p_illegal_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> $past(any_legal));
    p_offset_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> lk_loc_o[BASE_LSB-1:0] == $past(lk_addr_i[BASE_LSB-1:0]));
endmodule

bind inbound_window_decoder iwd_checker #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
    .lk_valid_o(lk_valid_o), .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o),
    .lk_loc_o(lk_loc_o), .win_cfg(win_cfg)
);

// File: tb/inbound_window_decoder_tb_top.sv
module inbound_window_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid_i = 1'b0;
    logic [31:0] lk_addr_i = '0;
    logic        lk_valid_o, lk_hit_o;
    logic [1:0]  lk_idx_o;
    logic [31:0] lk_loc_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    inbound_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid_i(lk_valid_i),
        .lk_addr_i(lk_addr_i), .lk_valid_o(lk_valid_o), .lk_hit_o(lk_hit_o),
        .lk_idx_o(lk_idx_o), .lk_loc_o(lk_loc_o)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        h;
        logic [1:0]  i;
        logic [31:0] l;
    } vec_t;

    // w0: base 0x100, 16 MB; w1: base 0x108, 1 MB (inside w0); w2: 2 GB, junk low base
    localparam vec_t VECS [8] = '{
        '{32'h1012_3456, 1'b1, 2'd0, 32'h0012_3456},
        '{32'h1080_0010, 1'b1, 2'd0, 32'h0080_0010},
        '{32'h1100_0000, 1'b0, 2'd0, 32'h0000_0000},
        '{32'hFFFF_FFFC, 1'b1, 2'd2, 32'h7FFF_FFFC},
        '{32'h8000_0000, 1'b1, 2'd2, 32'h0000_0000},
        '{32'h0FFF_FFFF, 1'b0, 2'd0, 32'h0000_0000},
        '{32'h10FF_FFFF, 1'b1, 2'd0, 32'h00FF_FFFF},
        '{32'h7FFF_FFFF, 1'b0, 2'd0, 32'h0000_0000}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look(input logic [31:0] a, input logic h, input logic [1:0] i,
                        input logic [31:0] l, input string req);
        @(negedge clk);
        lk_valid_i = 1'b1; lk_addr_i = a;
        @(negedge clk);
        lk_valid_i = 1'b0;
        check({lk_valid_o, lk_hit_o, lk_idx_o, lk_loc_o} == {1'b1, h, i, l}, req,
              64'({lk_valid_o, lk_hit_o, lk_idx_o, lk_loc_o}), 64'({1'b1, h, i, l}));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and no hit
        rd_chk(8'h00, 32'h000F_0000, "R1 io reset");
        rd_chk(8'h50, 32'h000F_0000, "R1 w0 reset");
        rd_chk(8'h54, 32'h000F_0000, "R1 w1 reset");
        rd_chk(8'h58, 32'h000F_0000, "R1 w2 reset");
        look(32'h0000_0000, 1'b0, 2'd0, 32'h0, "R1 no hit after reset");

        // R8: valid drops one cycle after request ends
        @(negedge clk);
        check(lk_valid_o == 1'b0 && lk_hit_o == 1'b0, "R8 idle valid low",
              64'({lk_valid_o, lk_hit_o}), 64'(0));

        // R2: program windows and read back
        wr(8'h50, 32'h1004_ABCD);
        wr(8'h54, 32'h1080_FFFF);
        wr(8'h58, 32'h8F3B_1234);
        rd_chk(8'h50, 32'h1004_0000, "R2 w0 readback");
        rd_chk(8'h54, 32'h1080_0000, "R2 w1 readback");
        rd_chk(8'h58, 32'h8F3B_0000, "R2 w2 readback");

        // R4 R6 R7 R9: table walk
        foreach (VECS[k]) begin
            look(VECS[k].a, VECS[k].h, VECS[k].i, VECS[k].l, "R4/R6/R7/R9 vector");
        end
        // R4: 2 GB window ignores stored base bits below bit 31
        look(32'h8000_1000, 1'b1, 2'd2, 32'h0000_1000, "R4 2GB low base ignored");

        // R3: unmapped offsets
        wr(8'h5C, 32'h0000_0000);
        wr(8'h04, 32'h1000_0000);
        rd_chk(8'h5C, 32'h0, "R3 unmapped read zero");
        rd_chk(8'h04, 32'h0, "R3 unmapped read zero 04");
        rd_chk(8'h50, 32'h1004_0000, "R3 w0 untouched");
        look(32'h0000_0010, 1'b0, 2'd0, 32'h0, "R3 no new window");

        // R5 R6: disable w0 with 0xC, w1 takes over
        wr(8'h50, 32'h100C_0000);
        look(32'h1080_0010, 1'b1, 2'd1, 32'h0000_0010, "R5 code C skipped, R6 w1 wins");
        look(32'h1012_3456, 1'b0, 2'd0, 32'h0, "R5 code C no hit");
        wr(8'h50, 32'h100F_0000);
        look(32'h1000_0000, 1'b0, 2'd0, 32'h0, "R5 code F no hit");
        wr(8'h54, 32'h108D_0000);
        look(32'h1080_0010, 1'b0, 2'd0, 32'h0, "R5 code D no hit");

        // R10: I/O size register stored but inert
        wr(8'h00, 32'h1080_5555);
        rd_chk(8'h00, 32'h1080_0000, "R2 io readback");
        look(32'h1080_0010, 1'b0, 2'd0, 32'h0, "R10 io size no hit");
        look(32'hC000_0000, 1'b1, 2'd2, 32'h4000_0000, "R10 w2 unaffected");

        // R4: smallest window exact boundary
        wr(8'h54, 32'h0010_0000);
        look(32'h001F_FFFF, 1'b1, 2'd1, 32'h000F_FFFF, "R4 1MB top edge");
        look(32'h0020_0000, 1'b0, 2'd0, 32'h0, "R4 1MB past edge");

        summary();
        $finish;
    end
endmodule